// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags and Sequential Multiplier

This block is the arithmetic and logic unit of a small accumulator-based processor. Each operation takes an operation code, the accumulator value, the index register value, a memory operand and the current condition code byte. It returns an 8-bit result and an updated condition code byte holding half-carry (H), interrupt mask (I), negative (N), zero (Z) and carry/borrow (C). Two-operand operations combine the accumulator with the memory operand. Single-operand operations (shifts, rotates, complement, negate, increment, decrement) act on the memory operand, so the surrounding core routes A, X or a memory byte there.

A request is offered by raising `start`. It is taken at any rising edge where `busy` is low. Every operation except multiply is registered, so its outputs appear with a one-cycle `done` pulse right after the accepting edge. The unsigned multiply of A by X runs as a shift-and-add sequence with one partial product step per cycle. `busy` is high while the sequence runs. The low product byte goes to `resultOut` for A, and the high byte goes to `idxOut` for X. `writeBack` and `idxWrite` tell the core which register files to update in the `done` cycle. The parameter `MUL_CYCLES` sets the multiply latency and must be at least `DATA_W + 2`.

Top module: `alu_flags_unit`

## Requirements
- R1: After reset, `busy`, `done`, `writeBack` and `idxWrite` are 0, `resultOut` and `idxOut` are 0x00, and `ccrOut` is 0xE0.
- R2: Operation codes are ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, AND=5, OR=6, XOR=7, BIT=8, LSL=9, LSR=10, ASR=11, ROL=12, ROR=13, COM=14, NEG=15, INC=16, DEC=17, MUL=18. A non-multiply request taken at an edge presents its outputs with `done`=1 in the following cycle. `done` returns to 0 one cycle later unless a new request was taken.
- R3: ADD and ADC (ADC also adds C) give A+M. C is the carry out of bit 7 and H is the carry from bit 3 into bit 4.
- R4: SUB, SBC and CMP compute A−M (SBC also subtracts C). C is set when a borrow occurs and H is kept. CMP gives `writeBack`=0.
- R5: AND, OR, XOR and BIT update N and Z only and keep C and H. BIT performs AND with `writeBack`=0.
- R6: Shifts and rotates act on M, with the bit leaving the byte going to C. LSL fills with 0. LSR fills bit 7 with 0. ASR keeps bit 7. ROL and ROR fill with the old C.
- R7: COM gives the bitwise inverse and sets C. NEG gives 0−M and sets C exactly when M is nonzero.
- R8: INC and DEC give M+1 and M−1 modulo 256 and keep C and H.
- R9: For every operation except MUL, N equals bit 7 of the result and Z is 1 exactly when the result is 0x00. In every `done` cycle, `ccrOut` bit 3 (I) equals the I bit given with the request, and bits 7:5 read 1. The bit order is 7:5=111, 4=H, 3=I, 2=N, 1=Z, 0=C.
- R10: MUL takes A×X unsigned. `busy` is 1 for the 10 cycles after the accepting edge. `done`, `writeBack` and `idxWrite` are 1 in the 11th cycle, with `resultOut` as the low byte and `idxOut` as the high byte.
- R11: MUL clears H and C and keeps N, Z and I as given with the request.
- R12: `start` while `busy` is 1 is ignored. The running multiply result and its timing are unchanged, even when the operands and operation code change.
- R13: Codes 19 to 31 complete with `done`=1, `writeBack`=0, `idxWrite`=0, and `ccrOut` equal to the given byte with bits 7:5 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation |
| opCode | input | 5 | Operation code |
| accIn | input | 8 | Accumulator operand |
| idxIn | input | 8 | Index register operand (multiplier) |
| memIn | input | 8 | Memory operand, or the register being modified |
| ccrIn | input | 8 | Current condition code byte |
| busy | output | 1 | Multiply in progress, requests ignored |
| done | output | 1 | Outputs valid this cycle |
| writeBack | output | 1 | Write `resultOut` to its destination |
| idxWrite | output | 1 | Write `idxOut` to the index register |
| resultOut | output | 8 | Result, or low product byte |
| idxOut | output | 8 | High product byte |
| ccrOut | output | 8 | Updated condition code byte |

## Verification
The hardest situation to reach is a request arriving while a multiply is in flight. The bench has to hold `start` high, with changing operands and codes that include a second multiply, across the whole busy window. It then shows that the product and its done cycle are untouched. The operand extremes 0×0, 255×255 and 1×255 exercise the final carry of the shift-and-add chain. Directed values hit the flag corners: the half-carry boundary 0x0F+0x01, carry-out and zero together, negate of 0x00 and 0x80, and rotates that pull the incoming carry. Seeded random requests run back to back, so `done` stays high across consecutive requests.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  localparam int OP_W = 5;

  localparam logic [OP_W-1:0] OP_ADD = 5'd0;
  localparam logic [OP_W-1:0] OP_ADC = 5'd1;
  localparam logic [OP_W-1:0] OP_SUB = 5'd2;
  localparam logic [OP_W-1:0] OP_SBC = 5'd3;
  localparam logic [OP_W-1:0] OP_CMP = 5'd4;
  localparam logic [OP_W-1:0] OP_AND = 5'd5;
  localparam logic [OP_W-1:0] OP_OR  = 5'd6;
  localparam logic [OP_W-1:0] OP_XOR = 5'd7;
  localparam logic [OP_W-1:0] OP_BIT = 5'd8;
  localparam logic [OP_W-1:0] OP_LSL = 5'd9;
  localparam logic [OP_W-1:0] OP_LSR = 5'd10;
  localparam logic [OP_W-1:0] OP_ASR = 5'd11;
  localparam logic [OP_W-1:0] OP_ROL = 5'd12;
  localparam logic [OP_W-1:0] OP_ROR = 5'd13;
  localparam logic [OP_W-1:0] OP_COM = 5'd14;
  localparam logic [OP_W-1:0] OP_NEG = 5'd15;
  localparam logic [OP_W-1:0] OP_INC = 5'd16;
  localparam logic [OP_W-1:0] OP_DEC = 5'd17;
  localparam logic [OP_W-1:0] OP_MUL = 5'd18;

  // condition code bit positions (decoded by the core's branch logic)
  localparam int CC_C = 0;
  localparam int CC_Z = 1;
  localparam int CC_N = 2;
  localparam int CC_I = 3;
  localparam int CC_H = 4;
  localparam logic [7:0] CC_RESET = 8'hE0;

  typedef struct packed {
    logic takeOp;     // latch a single-cycle result
    logic mulLoad;    // capture multiply operands
    logic mulStep;    // one shift-and-add step
    logic mulFinish;  // publish the product
  } aluStrobe_t;
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] mem,
  input  logic [7:0]        ccrIn,
  output logic [DATA_W-1:0] res,
  output logic [7:0]        ccrNext,
  output logic              wb
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] ONE = 1;

  logic              carryIn;
  logic [DATA_W:0]   addSum;
  logic [DATA_W:0]   subDiff;
  logic [HALF:0]     lowSum;
  logic              hNew, cNew, nzTouch;

  always_comb begin
    carryIn = ((op == OP_ADC) || (op == OP_SBC)) && ccrIn[CC_C];
    addSum  = {1'b0, acc} + {1'b0, mem} + {{DATA_W{1'b0}}, carryIn};
    lowSum  = {1'b0, acc[HALF-1:0]} + {1'b0, mem[HALF-1:0]} + {{HALF{1'b0}}, carryIn};
    subDiff = {1'b0, acc} - {1'b0, mem} - {{DATA_W{1'b0}}, carryIn};

    res     = '0;
    wb      = 1'b1;
    hNew    = ccrIn[CC_H];
    cNew    = ccrIn[CC_C];
    nzTouch = 1'b1;

    case (op)
      OP_ADD, OP_ADC: begin
        res  = addSum[DATA_W-1:0];
        cNew = addSum[DATA_W];
        hNew = lowSum[HALF];
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        res  = subDiff[DATA_W-1:0];
        cNew = subDiff[DATA_W];
        wb   = (op != OP_CMP);
      end
      OP_AND, OP_BIT: begin
        res = acc & mem;
        wb  = (op != OP_BIT);
      end
      OP_OR:  res = acc | mem;
      OP_XOR: res = acc ^ mem;
      OP_LSL: begin
        res  = {mem[DATA_W-2:0], 1'b0};
        cNew = mem[DATA_W-1];
      end
      OP_LSR: begin
        res  = {1'b0, mem[DATA_W-1:1]};
        cNew = mem[0];
      end
      OP_ASR: begin
        res  = {mem[DATA_W-1], mem[DATA_W-1:1]};
        cNew = mem[0];
      end
      OP_ROL: begin
        res  = {mem[DATA_W-2:0], ccrIn[CC_C]};
        cNew = mem[DATA_W-1];
      end
      OP_ROR: begin
        res  = {ccrIn[CC_C], mem[DATA_W-1:1]};
        cNew = mem[0];
      end
      OP_COM: begin
        res  = ~mem;
        cNew = 1'b1;
      end
      OP_NEG: begin
        res  = {DATA_W{1'b0}} - mem;
        cNew = |mem;
      end
      OP_INC: res = mem + ONE;
      OP_DEC: res = mem - ONE;
      default: begin
        wb      = 1'b0;
        nzTouch = 1'b0;
      end
    endcase

    ccrNext = {3'b111, hNew, ccrIn[CC_I],
               nzTouch ? res[DATA_W-1] : ccrIn[CC_N],
               nzTouch ? (res == '0)   : ccrIn[CC_Z],
               cNew};
  end
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_flags_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MUL_CYCLES = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [OP_W-1:0] op,
  output aluStrobe_t      strobe,
  output logic            busy,
  output logic            done
);
  localparam int CNT_W      = $clog2(MUL_CYCLES + 1);
  localparam int STEP_FLOOR = MUL_CYCLES - 1 - DATA_W;

  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             isMul;

  always_comb begin
    accept           = start && !busy;
    isMul            = (op == OP_MUL);
    strobe.takeOp    = accept && !isMul;
    strobe.mulLoad   = accept && isMul;
    strobe.mulStep   = busy && (cnt > CNT_W'(STEP_FLOOR));
    strobe.mulFinish = busy && (cnt == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= strobe.takeOp || strobe.mulFinish;
      if (strobe.mulLoad) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(MUL_CYCLES - 1);
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
        if (strobe.mulFinish) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strobe,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] idx,
  input  logic [DATA_W-1:0] mem,
  input  logic [7:0]        ccrIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [DATA_W-1:0] idxOut,
  output logic [7:0]        ccrOut,
  output logic              writeBack,
  output logic              idxWrite
);
  logic [DATA_W-1:0] coreRes;
  logic [7:0]        coreCcr;
  logic              coreWb;

  logic [DATA_W-1:0] mcand, prodHi, prodLo;
  logic [2:0]        keepInz;   // I, N, Z kept across multiply
  logic [DATA_W:0]   stepSum;

  alu_core #(.DATA_W(DATA_W)) u_core (
    .op(op), .acc(acc), .mem(mem), .ccrIn(ccrIn),
    .res(coreRes), .ccrNext(coreCcr), .wb(coreWb)
  );

  always_comb begin
    stepSum = {1'b0, prodHi} + (prodLo[0] ? {1'b0, mcand} : {(DATA_W+1){1'b0}});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand   <= '0;
      prodHi  <= '0;
      prodLo  <= '0;
      keepInz <= '0;
    end else if (strobe.mulLoad) begin
      mcand   <= acc;
      prodHi  <= '0;
      prodLo  <= idx;
      keepInz <= ccrIn[CC_I:CC_Z];
    end else if (strobe.mulStep) begin
      prodHi <= stepSum[DATA_W:1];
      prodLo <= {stepSum[0], prodLo[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut <= '0;
      idxOut    <= '0;
      ccrOut    <= CC_RESET;
      writeBack <= 1'b0;
      idxWrite  <= 1'b0;
    end else if (strobe.mulFinish) begin
      resultOut <= prodLo;
      idxOut    <= prodHi;
      ccrOut    <= {3'b111, 1'b0, keepInz, 1'b0};
      writeBack <= 1'b1;
      idxWrite  <= 1'b1;
    end else if (strobe.takeOp) begin
      resultOut <= coreRes;
      ccrOut    <= coreCcr;
      writeBack <= coreWb;
      idxWrite  <= 1'b0;
    end else begin
      writeBack <= 1'b0;
      idxWrite  <= 1'b0;
    end
  end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MUL_CYCLES = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] idxIn,
  input  logic [DATA_W-1:0] memIn,
  input  logic [7:0]        ccrIn,
  output logic              busy,
  output logic              done,
  output logic              writeBack,
  output logic              idxWrite,
  output logic [DATA_W-1:0] resultOut,
  output logic [DATA_W-1:0] idxOut,
  output logic [7:0]        ccrOut
);
  aluStrobe_t strobe;

  alu_ctrl #(.DATA_W(DATA_W), .MUL_CYCLES(MUL_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .op(opCode),
    .strobe(strobe), .busy(busy), .done(done)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .op(opCode),
    .acc(accIn), .idx(idxIn), .mem(memIn), .ccrIn(ccrIn),
    .resultOut(resultOut), .idxOut(idxOut), .ccrOut(ccrOut),
    .writeBack(writeBack), .idxWrite(idxWrite)
  );
endmodule

// File: rtl/alu_flags_checker.sv
module alu_flags_checker
  import alu_flags_pkg::*;
#(
  parameter int MUL_CYCLES = 11
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic [OP_W-1:0] opCode,
  input logic [7:0]      ccrIn,
  input logic            busy,
  input logic            done,
  input logic            writeBack,
  input logic            idxWrite,
  input logic [7:0]      ccrOut
);
  localparam int CNT_W = $clog2(MUL_CYCLES + 1);

  logic [CNT_W-1:0] busyLen;
  logic             taken;

  assign taken = start && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + CNT_W'(1);
    else           busyLen <= '0;
  end

  a_r10_busy_after_mul: assert property (@(posedge clk) disable iff (!rstN)
    (taken && opCode == OP_MUL) |=> busy);

  a_r10_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == CNT_W'(MUL_CYCLES - 1)));

  a_r10_done_on_finish: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done && idxWrite && writeBack));

  a_r11_mul_clears_hc: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!ccrOut[CC_H] && !ccrOut[CC_C]));

  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r9_top_ones: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (ccrOut[7:5] == 3'b111));

  a_r4_no_wb_compare: assert property (@(posedge clk) disable iff (!rstN)
    (taken && (opCode == OP_CMP || opCode == OP_BIT)) |=> (done && !writeBack));

  a_r5_logic_keeps_hc: assert property (@(posedge clk) disable iff (!rstN)
    (taken && (opCode == OP_AND || opCode == OP_OR || opCode == OP_XOR || opCode == OP_BIT))
    |=> (ccrOut[CC_C] == $past(ccrIn[CC_C]) && ccrOut[CC_H] == $past(ccrIn[CC_H])));

  a_r8_incdec_keeps_c: assert property (@(posedge clk) disable iff (!rstN)
    (taken && (opCode == OP_INC || opCode == OP_DEC)) |=> (ccrOut[CC_C] == $past(ccrIn[CC_C])));

  a_r13_undefined_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (taken && opCode > OP_MUL) |=> (done && !writeBack && !idxWrite));

  a_r12_no_retrigger: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$fell(busy) && $past(busy) && start) |=> (busy || done));
endmodule

bind alu_flags_unit alu_flags_checker #(.MUL_CYCLES(MUL_CYCLES)) u_checker (
  .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .ccrIn(ccrIn),
  .busy(busy), .done(done), .writeBack(writeBack), .idxWrite(idxWrite),
  .ccrOut(ccrOut)
);

// File: tb/alu_flags_unit_bench.sv
module alu_flags_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] accIn = '0, idxIn = '0, memIn = '0, ccrIn = '0;
  logic       busy, done, writeBack, idxWrite;
  logic [7:0] resultOut, idxOut, ccrOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flags_unit u_alu_flags_unit (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode),
    .accIn(accIn), .idxIn(idxIn), .memIn(memIn), .ccrIn(ccrIn),
    .busy(busy), .done(done), .writeBack(writeBack), .idxWrite(idxWrite),
    .resultOut(resultOut), .idxOut(idxOut), .ccrOut(ccrOut)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // expected {writeBack, result, ccr}
  function automatic logic [16:0] model(input logic [4:0] op, input logic [7:0] a,
                                        input logic [7:0] m, input logic [7:0] c);
    logic [7:0] r;
    logic       wb, h, cy, touch, cin;
    logic [8:0] wide;
    logic [4:0] nib;
    r = 8'h00; wb = 1'b1; h = c[4]; cy = c[0]; touch = 1'b1;
    cin = (op == 5'd1 || op == 5'd3) ? c[0] : 1'b0;
    case (op)
      5'd0, 5'd1: begin
        wide = {1'b0, a} + {1'b0, m} + {8'h00, cin};
        nib  = {1'b0, a[3:0]} + {1'b0, m[3:0]} + {4'h0, cin};
        r = wide[7:0]; cy = wide[8]; h = nib[4];
      end
      5'd2, 5'd3, 5'd4: begin
        r  = a - m - {7'h00, cin};
        cy = ({1'b0, a} < ({1'b0, m} + {8'h00, cin}));
        wb = (op != 5'd4);
      end
      5'd5: r = a & m;
      5'd6: r = a | m;
      5'd7: r = a ^ m;
      5'd8: begin r = a & m; wb = 1'b0; end
      5'd9:  begin r = m << 1; cy = m[7]; end
      5'd10: begin r = m >> 1; cy = m[0]; end
      5'd11: begin r = {m[7], m[7:1]}; cy = m[0]; end
      5'd12: begin r = {m[6:0], c[0]}; cy = m[7]; end
      5'd13: begin r = {c[0], m[7:1]}; cy = m[0]; end
      5'd14: begin r = 8'hFF ^ m; cy = 1'b1; end
      5'd15: begin r = 8'h00 - m; cy = (m != 8'h00); end
      5'd16: r = m + 8'h01;
      5'd17: r = m - 8'h01;
      default: begin wb = 1'b0; touch = 1'b0; end
    endcase
    return {wb, r, 3'b111, h, c[3],
            touch ? r[7] : c[2], touch ? (r == 8'h00) : c[1], cy};
  endfunction

  function automatic string tagOf(input logic [4:0] op);
    if (op <= 5'd1)  return "R3";
    if (op <= 5'd4)  return "R4";
    if (op <= 5'd8)  return "R5";
    if (op <= 5'd13) return "R6";
    if (op <= 5'd15) return "R7";
    if (op <= 5'd17) return "R8";
    return "R13";
  endfunction

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic runOp(input logic [4:0] op, input logic [7:0] a, input logic [7:0] m,
                       input logic [7:0] c);
    logic [16:0] e;
    string t;
    e = model(op, a, m, c);
    t = tagOf(op);
    start = 1'b1; opCode = op; accIn = a; memIn = m; ccrIn = c;
    idxIn = 8'($urandom);
    @(negedge clk);
    start = 1'b0;
    chk("R2", "done", {15'h0, done}, 16'h1);
    chk("R2", "busy", {15'h0, busy}, 16'h0);
    chk(t, "writeBack", {15'h0, writeBack}, {15'h0, e[16]});
    chk(t, "idxWrite", {15'h0, idxWrite}, 16'h0);
    if (e[16]) chk(t, "result", {8'h0, resultOut}, {8'h0, e[15:8]});
    chk(t, "ccr", {8'h0, ccrOut}, {8'h0, e[7:0]});
    chk("R9", "n_z_i_top", {13'h0, ccrOut[7:5]}, 16'h7);
  endtask

  task automatic runMul(input logic [7:0] a, input logic [7:0] x, input logic [7:0] c,
                        input bit interfere);
    logic [15:0] prod;
    prod = {8'h00, a} * {8'h00, x};
    start = 1'b1; opCode = 5'd18; accIn = a; idxIn = x; ccrIn = c;
    memIn = 8'($urandom);
    @(negedge clk);
    chk("R10", "busy_first", {14'h0, busy, done}, 16'h2);
    for (int k = 1; k <= 9; k++) begin
      start = interfere;
      if (interfere) begin
        opCode = 5'($urandom_range(0, 18));
        accIn = 8'($urandom); idxIn = 8'($urandom);
        memIn = 8'($urandom); ccrIn = 8'($urandom);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      chk(interfere ? "R12" : "R10", "busy_window", {14'h0, busy, done}, 16'h2);
    end
    start = 1'b0;
    @(negedge clk);
    chk(interfere ? "R12" : "R10", "done_busy", {14'h0, busy, done}, 16'h1);
    chk(interfere ? "R12" : "R10", "product", {idxOut, resultOut}, prod);
    chk("R10", "writes", {14'h0, writeBack, idxWrite}, 16'h3);
    chk("R11", "ccr", {8'h0, ccrOut}, {8'h0, 3'b111, 1'b0, c[3:1], 1'b0});
    @(negedge clk);
    chk("R10", "done_pulse", {14'h0, done, idxWrite}, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seedVal;
    logic [4:0] rop;
    seedVal = $urandom(32'h0C0FFEE5);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "flags_out", {11'h0, busy, done, writeBack, idxWrite, 1'b0}, 16'h0);
    chk("R1", "data_out", {idxOut, resultOut}, 16'h0000);
    chk("R1", "ccr", {8'h0, ccrOut}, 16'h00E0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    runOp(5'd0, 8'h0F, 8'h01, 8'h00);   // R3 half carry
    runOp(5'd0, 8'hFF, 8'h01, 8'h00);   // R3 carry and zero
    runOp(5'd1, 8'h7F, 8'h00, 8'h01);   // R3 carry in, negative
    runOp(5'd2, 8'h00, 8'h01, 8'h10);   // R4 borrow, H kept
    runOp(5'd3, 8'h05, 8'h05, 8'h01);   // R4 borrow from carry in
    runOp(5'd4, 8'h42, 8'h42, 8'h00);   // R4 compare equal
    runOp(5'd8, 8'hF0, 8'h0F, 8'h11);   // R5 bit test zero
    runOp(5'd11, 8'h81, 8'h81, 8'h00);  // R6 asr keeps bit 7
    runOp(5'd13, 8'h00, 8'h02, 8'h01);  // R6 ror pulls carry
    runOp(5'd12, 8'h00, 8'h80, 8'h00);  // R6 rol out to carry
    runOp(5'd15, 8'h00, 8'h00, 8'h01);  // R7 neg zero clears C
    runOp(5'd15, 8'h00, 8'h80, 8'h00);  // R7 neg 0x80
    runOp(5'd14, 8'h00, 8'h55, 8'h00);  // R7 com sets C
    runOp(5'd16, 8'h00, 8'hFF, 8'h01);  // R8 inc wraps, C kept
    runOp(5'd17, 8'h00, 8'h00, 8'h00);  // R8 dec wraps
    runOp(5'd25, 8'h12, 8'h34, 8'h1F);  // R13 undefined
    @(negedge clk);
    chk("R2", "done_pulse", {14'h0, done, writeBack}, 16'h0);

    runMul(8'h00, 8'h00, 8'h0E, 1'b0);
    runMul(8'hFF, 8'hFF, 8'h11, 1'b0);
    runMul(8'h01, 8'hFF, 8'h08, 1'b0);
    runMul(8'h80, 8'h02, 8'hFF, 1'b1);  // R12 requests during busy

    for (int i = 0; i < 400; i++) begin
      rop = 5'($urandom_range(0, 31));
      if (rop == 5'd18) rop = 5'd2;
      runOp(rop, 8'($urandom), 8'($urandom), 8'($urandom));
    end
    for (int i = 0; i < 30; i++) begin
      runMul(8'($urandom), 8'($urandom), 8'($urandom), (i % 3) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule